// File: doc/BRIEF.md
# Asymmetric Dual-Issue Pipeline Assigner

This block sits at the end of a two-wide decode stage. It receives the group codes of the two instructions decoded together, with the older one in slot 0. It also receives the busy state of four execution pipelines: integer, load/store, branch and floating-point. From these it decides which instructions issue this cycle and which pipeline each one is sent to. Slot 0 is always served first. Slot 1 can only use a pipeline that slot 0 has left free. A slot 1 instruction that cannot go stays in the decode latch, and the hold output reports it.

Two groups are not tied to a single pipeline. A "both" group instruction can run on either the integer or the load/store pipeline, and it is steered by what its partner needs. A serial group instruction takes the integer and load/store pipelines together and may only leave from slot 0. A two-bit stall input from the operand dependency check can block slot 0 and slot 1, or slot 1 alone. All decisions are registered, so the outputs show the decision one clock after the inputs are presented.

Top module: `dual_issue_assigner`

## Requirements
- R1: All outputs are registered and reflect the inputs sampled at the previous rising clock edge; while rst_n is low every output is zero.
- R2: Group codes are 3 bits: 0 integer, 1 load/store, 2 branch, 3 floating-point, 4 both (integer or load/store), 5 serial. Select bit 0 is the integer pipe, bit 1 load/store, bit 2 branch and bit 3 floating-point. Codes 0 to 3 go to the pipe with the same index.
- R3: A slot issues only to pipes whose busy bit is 0; slot 1 also cannot use a pipe chosen by slot 0. hold1_o is 1 exactly when slot 0 issues and slot 1 does not.
- R4: A "both" instruction targets load/store when its partner is integer and targets integer otherwise. When both slots are "both", slot 0 takes integer and slot 1 takes load/store.
- R5: When the targeted pipe of a "both" instruction is busy or taken by slot 0, the instruction uses the other of integer and load/store if that one is available.
- R6: A serial instruction in slot 0 issues only when the integer and load/store pipes are both free, and it selects both of them (select 4'b0011). Slot 1 never issues alongside it. A serial instruction in slot 1 never issues.
- R7: Slot 1 never issues in a cycle in which slot 0 does not issue.
- R8: stall bit 0 blocks slot 0 and slot 1; stall bit 1 blocks slot 1 only.
- R9: Group codes 6 and 7 never issue. In slot 0 they also block slot 1.
- R10: A slot's select is zero when it does not issue and has exactly one bit set when it issues, except for the serial case of R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| grp0_i | input | 3 | Group code of slot 0 (older instruction) |
| grp1_i | input | 3 | Group code of slot 1 |
| busy_i | input | 4 | Pipe busy flags: [0] integer, [1] load/store, [2] branch, [3] floating-point |
| stall_i | input | 2 | Operand stall: [0] blocks slots 0 and 1, [1] blocks slot 1 |
| iss0_o | output | 1 | Slot 0 issues |
| iss1_o | output | 1 | Slot 1 issues |
| hold1_o | output | 1 | Slot 1 is kept for redecode while slot 0 leaves |
| sel0_o | output | 4 | Pipe chosen for slot 0 |
| sel1_o | output | 4 | Pipe chosen for slot 1 |

## Verification
The bench runs every combination of the two group codes, the busy flags and the stall bits. These cases include undefined codes, serial instructions in either slot and "both" pairs. It targets the pairing of a "both" instruction with an integer partner: a design that ignores the partner would send both instructions to the integer pipe, or would hold slot 1 for no reason. It also targets the fallback when the integer pipe is busy, where a design without a fallback would leave a free load/store pipe unused. Finally, it checks that a serial instruction and a blocked slot 0 each stop slot 1; a design that got either wrong would issue slot 1 out of order or put two instructions on the same pipe.

// File: rtl/dual_issue_pkg.sv
package dual_issue_pkg;
    localparam int GRP_W  = 3;
    localparam int NPIPE  = 4;
    localparam int NSLOT  = 2;

    localparam logic [GRP_W-1:0] C_INT  = 3'd0;
    localparam logic [GRP_W-1:0] C_LS   = 3'd1;
    localparam logic [GRP_W-1:0] C_BR   = 3'd2;
    localparam logic [GRP_W-1:0] C_FE   = 3'd3;
    localparam logic [GRP_W-1:0] C_BOTH = 3'd4;
    localparam logic [GRP_W-1:0] C_SER  = 3'd5;

    localparam int P_INT = 0;
    localparam int P_LS  = 1;
    localparam int P_BR  = 2;
    localparam int P_FE  = 3;

    typedef logic [NPIPE-1:0] pmask_t;

    typedef struct packed {
        logic   iss0;
        logic   iss1;
        logic   hold1;
        pmask_t sel0;
        pmask_t sel1;
    } issue_t;
endpackage

// File: rtl/slot_decode.sv
module slot_decode
    import dual_issue_pkg::*;
#(
    parameter int SLOT = 0
) (
    input  logic [GRP_W-1:0] grp,
    input  logic [GRP_W-1:0] partner,
    output pmask_t           prim,
    output pmask_t           alt,
    output logic             legal
);
    logic to_ls;

    always_comb begin
        prim  = '0;
        alt   = '0;
        legal = 1'b1;
        // slot 1 of a both/both pair takes load/store; an integer partner pushes to load/store
        to_ls = (partner == C_INT) || ((SLOT != 0) && (partner == C_BOTH));
        case (grp)
            C_INT: prim[P_INT] = 1'b1;
            C_LS:  prim[P_LS]  = 1'b1;
            C_BR:  prim[P_BR]  = 1'b1;
            C_FE:  prim[P_FE]  = 1'b1;
            C_BOTH: begin
                if (to_ls) begin
                    prim[P_LS]  = 1'b1;
                    alt[P_INT]  = 1'b1;
                end else begin
                    prim[P_INT] = 1'b1;
                    alt[P_LS]   = 1'b1;
                end
            end
            C_SER: begin
                if (SLOT == 0) begin
                    prim[P_INT] = 1'b1;
                    prim[P_LS]  = 1'b1;
                end else begin
                    legal = 1'b0;
                end
            end
            default: legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/issue_arbiter.sv
module issue_arbiter
    import dual_issue_pkg::*;
(
    input  pmask_t      prim0,
    input  pmask_t      alt0,
    input  logic        legal0,
    input  logic        ser0,
    input  pmask_t      prim1,
    input  pmask_t      alt1,
    input  logic        legal1,
    input  pmask_t      busy,
    input  logic [1:0]  stall,
    output issue_t      res
);
    pmask_t free0;
    pmask_t free1;
    pmask_t pick0;
    pmask_t pick1;

    function automatic pmask_t choose(pmask_t p, pmask_t a, pmask_t fr);
        pmask_t r;
        r = '0;
        if ((p != '0) && ((p & ~fr) == '0))
            r = p;
        else if ((a != '0) && ((a & ~fr) == '0))
            r = a;
        return r;
    endfunction

    always_comb begin
        free0 = ~busy;
        pick0 = '0;
        if (legal0 && !stall[0])
            pick0 = choose(prim0, alt0, free0);

        free1 = free0 & ~pick0;
        pick1 = '0;
        if ((pick0 != '0) && legal1 && !ser0 && (stall == 2'b00))
            pick1 = choose(prim1, alt1, free1);

        res.sel0  = pick0;
        res.sel1  = pick1;
        res.iss0  = (pick0 != '0);
        res.iss1  = (pick1 != '0);
        res.hold1 = (pick0 != '0) && (pick1 == '0);
    end
endmodule

// File: rtl/dual_issue_assigner.sv
module dual_issue_assigner
    import dual_issue_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [GRP_W-1:0] grp0_i,
    input  logic [GRP_W-1:0] grp1_i,
    input  logic [NPIPE-1:0] busy_i,
    input  logic [1:0]       stall_i,
    output logic             iss0_o,
    output logic             iss1_o,
    output logic             hold1_o,
    output logic [NPIPE-1:0] sel0_o,
    output logic [NPIPE-1:0] sel1_o
);
    logic [NSLOT-1:0][GRP_W-1:0] grp;
    pmask_t [NSLOT-1:0]          prim;
    pmask_t [NSLOT-1:0]          alt;
    logic   [NSLOT-1:0]          legal;
    issue_t                      arb;
    issue_t                      st_d;
    issue_t                      st_q;

    assign grp[0] = grp0_i;
    assign grp[1] = grp1_i;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        slot_decode #(.SLOT(s)) i_dec (
            .grp     (grp[s]),
            .partner (grp[NSLOT-1-s]),
            .prim    (prim[s]),
            .alt     (alt[s]),
            .legal   (legal[s])
        );
    end

    issue_arbiter i_arb (
        .prim0  (prim[0]),
        .alt0   (alt[0]),
        .legal0 (legal[0]),
        .ser0   (grp0_i == C_SER),
        .prim1  (prim[1]),
        .alt1   (alt[1]),
        .legal1 (legal[1]),
        .busy   (busy_i),
        .stall  (stall_i),
        .res    (arb)
    );

    always_comb begin
        st_d = arb;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign iss0_o  = st_q.iss0;
    assign iss1_o  = st_q.iss1;
    assign hold1_o = st_q.hold1;
    assign sel0_o  = st_q.sel0;
    assign sel1_o  = st_q.sel1;
endmodule

// File: rtl/dual_issue_chk.sv
module dual_issue_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] busy_i,
    input logic [1:0] stall_i,
    input logic       iss0_o,
    input logic       iss1_o,
    input logic       hold1_o,
    input logic [3:0] sel0_o,
    input logic [3:0] sel1_o
);
    a_r7_second_needs_first: assert property (@(posedge clk) disable iff (!rst_n)
        iss1_o |-> iss0_o);

    a_r3_no_shared_pipe: assert property (@(posedge clk) disable iff (!rst_n)
        (sel0_o & sel1_o) == 4'b0000);

    a_r3_busy_respected: assert property (@(posedge clk) disable iff (!rst_n)
        (iss0_o || iss1_o) |-> (((sel0_o | sel1_o) & $past(busy_i)) == 4'b0000));

    a_r8_stall_first: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stall_i[0]) |-> (!iss0_o && !iss1_o));

    a_r8_stall_second: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stall_i[1]) |-> !iss1_o);

    a_r10_idle_zero0: assert property (@(posedge clk) disable iff (!rst_n)
        !iss0_o |-> (sel0_o == 4'b0000));

    a_r10_idle_zero1: assert property (@(posedge clk) disable iff (!rst_n)
        !iss1_o |-> (sel1_o == 4'b0000));

    a_r10_shape0: assert property (@(posedge clk) disable iff (!rst_n)
        iss0_o |-> (($countones(sel0_o) == 1) || (sel0_o == 4'b0011)));

    a_r10_shape1: assert property (@(posedge clk) disable iff (!rst_n)
        iss1_o |-> ($countones(sel1_o) == 1));

    a_r6_serial_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (sel0_o == 4'b0011) |-> (!iss1_o && hold1_o));
endmodule

bind dual_issue_assigner dual_issue_chk i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy_i  (busy_i),
    .stall_i (stall_i),
    .iss0_o  (iss0_o),
    .iss1_o  (iss1_o),
    .hold1_o (hold1_o),
    .sel0_o  (sel0_o),
    .sel1_o  (sel1_o)
);

// File: tb/test_dual_issue_assigner.sv
`timescale 1ns/1ps
module test_dual_issue_assigner;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] grp0 = 3'd0;
    logic [2:0] grp1 = 3'd0;
    logic [3:0] busy = 4'd0;
    logic [1:0] stall = 2'd0;
    logic       iss0, iss1, hold1;
    logic [3:0] sel0, sel1;
    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    dual_issue_assigner i_dual_issue_assigner (
        .clk(clk), .rst_n(rst_n), .grp0_i(grp0), .grp1_i(grp1),
        .busy_i(busy), .stall_i(stall), .iss0_o(iss0), .iss1_o(iss1),
        .hold1_o(hold1), .sel0_o(sel0), .sel1_o(sel1));

    // candidate pipes of one slot, in order of preference, from R2/R4/R6/R9
    function automatic logic [3:0] want(int slot, logic [2:0] g, logic [2:0] other, int pref);
        logic ls_first;
        ls_first = (other == 3'd0) || (slot == 1 && other == 3'd4);
        if (g <= 3'd3) return (pref == 0) ? (4'b0001 << g) : 4'b0000;
        if (g == 3'd4) begin
            if (pref == 0) return ls_first ? 4'b0010 : 4'b0001;
            return ls_first ? 4'b0001 : 4'b0010;   // R5 fallback
        end
        if (g == 3'd5 && slot == 0 && pref == 0) return 4'b0011;
        return 4'b0000;
    endfunction

    function automatic logic [10:0] model(logic [2:0] g0, logic [2:0] g1,
                                          logic [3:0] bz, logic [1:0] st);
        logic [3:0] s0, s1, c;
        s0 = 4'b0000;
        s1 = 4'b0000;
        if (!st[0]) begin
            for (int p = 0; p < 2; p++) begin
                c = want(0, g0, g1, p);
                if (s0 == 4'b0000 && c != 4'b0000 && (c & bz) == 4'b0000) s0 = c;
            end
        end
        if (s0 != 4'b0000 && st == 2'b00 && g0 != 3'd5) begin
            for (int p = 0; p < 2; p++) begin
                c = want(1, g1, g0, p);
                if (s1 == 4'b0000 && c != 4'b0000 && (c & (bz | s0)) == 4'b0000) s1 = c;
            end
        end
        return {s0 != 4'b0000, s1 != 4'b0000, (s0 != 4'b0000) && (s1 == 4'b0000), s0, s1};
    endfunction

    task automatic compare(string req, logic [10:0] exp);
        logic [10:0] act;
        act = {iss0, iss1, hold1, sel0, sel1};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s g0=%0d g1=%0d busy=%b stall=%b actual=%b expected=%b",
                     req, grp0, grp1, busy, stall, act, exp);
        end
    endtask

    task automatic drive(logic [2:0] g0, logic [2:0] g1, logic [3:0] bz, logic [1:0] st);
        @(negedge clk);
        grp0 = g0; grp1 = g1; busy = bz; stall = st;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #750000;
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        grp0 = 3'd4; grp1 = 3'd0;
        repeat (3) @(posedge clk);
        #1;
        compare("R1", 11'b0);   // R1 reset clears outputs
        @(negedge clk);
        rst_n = 1'b1;

        // directed cases with hand-computed values
        drive(3'd4, 3'd0, 4'b0000, 2'b00); compare("R4", {3'b110, 4'b0010, 4'b0001});
        drive(3'd4, 3'd4, 4'b0000, 2'b00); compare("R4", {3'b110, 4'b0001, 4'b0010});
        drive(3'd4, 3'd1, 4'b0001, 2'b00); compare("R5", {3'b101, 4'b0010, 4'b0000});
        drive(3'd1, 3'd4, 4'b0000, 2'b00); compare("R5", {3'b110, 4'b0010, 4'b0001});
        drive(3'd5, 3'd2, 4'b0000, 2'b00); compare("R6", {3'b101, 4'b0011, 4'b0000});
        drive(3'd5, 3'd2, 4'b0010, 2'b00); compare("R6", {3'b000, 4'b0000, 4'b0000});
        drive(3'd2, 3'd5, 4'b0000, 2'b00); compare("R6", {3'b101, 4'b0100, 4'b0000});
        drive(3'd0, 3'd2, 4'b0001, 2'b00); compare("R7", {3'b000, 4'b0000, 4'b0000});
        drive(3'd0, 3'd0, 4'b0000, 2'b00); compare("R3", {3'b101, 4'b0001, 4'b0000});
        drive(3'd7, 3'd0, 4'b0000, 2'b00); compare("R9", {3'b000, 4'b0000, 4'b0000});
        drive(3'd0, 3'd1, 4'b0000, 2'b10); compare("R8", {3'b101, 4'b0001, 4'b0000});
        drive(3'd0, 3'd1, 4'b0000, 2'b01); compare("R8", {3'b000, 4'b0000, 4'b0000});
        drive(3'd3, 3'd2, 4'b0000, 2'b00); compare("R2", {3'b110, 4'b1000, 4'b0100});
        drive(3'd2, 3'd3, 4'b1000, 2'b00); compare("R10", {3'b101, 4'b0100, 4'b0000});

        // exhaustive sweep
        for (int a = 0; a < 8; a++)
            for (int b = 0; b < 8; b++)
                for (int z = 0; z < 16; z++)
                    for (int s = 0; s < 4; s++) begin
                        string lbl;
                        drive(3'(a), 3'(b), 4'(z), 2'(s));
                        if (s != 0)                 lbl = "R8";
                        else if (a > 5 || b > 5)    lbl = "R9";
                        else if (a == 5 || b == 5)  lbl = "R6";
                        else if ((a == 4 || b == 4) && z[1:0] != 2'b00) lbl = "R5";
                        else if (a == 4 || b == 4)  lbl = "R4";
                        else if (z != 0)            lbl = "R3";
                        else                        lbl = "R2";
                        compare(lbl, model(3'(a), 3'(b), 4'(z), 2'(s)));
                    end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule